// File: doc/BRIEF.md
# Synchronous Burst Memory Command Controller

This block is the front end of a synchronous static memory with flow-through reads. On each rising clock edge it samples three chip selects, two address strobes (a processor strobe and a controller strobe), a burst-advance input, a global write input, a byte-write master enable and one write enable for each byte lane. From these it picks a single operation for that edge: deselect, start a burst with a read, start a burst with a write, continue or suspend a burst as a read or a write, or do nothing. The operation is applied to a small behavioural array of four 9-bit lanes, 36 bits in all.

Burst addresses come from a two-bit counter under the registered start address. The counter steps in either linear or interleaved order. Reads are flow-through: the word at the address latched on an edge appears right after that edge. A drive flag stands in for the tri-state data pins. A sleep input puts the block into a dormant state after a fixed number of clock edges and brings it back out after the same number.

Top module: `sbs_ctrl_top`

## Requirements
- R1: The block is selected only when `cen1_n`=0, `cen2`=1 and `cen3_n`=0 on an edge where either strobe is low. Any other select pattern on such an edge is a deselect. A deselect writes nothing, ends the burst and forces `rd_drive` low.
- R2: A selected edge with `ads_proc_n` low always reads the word at `addr`. Every write input is ignored on that edge.
- R3: A write is requested when `gw_n`=0, or when `bwe_n`=0 and at least one `bw_n[i]`=0. `gw_n`=0 writes all four lanes. Otherwise lane i, which is bits 9i to 9i+8, is written when `bw_n[i]`=0.
- R4: A selected edge with `ads_ctrl_n` low and `ads_proc_n` high writes `wdata` at `addr` on that same edge when a write is requested. With no write requested, that edge is a read of `addr`.
- R5: When a burst is open and both strobes are high, `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current one. A requested write goes to that address, and otherwise it is read. With no burst open (after reset or a deselect), such edges do nothing.
- R6: Burst offsets k = 0..3 keep the upper address bits of the start address. With `lin_mode`=1 the two low bits are (start+k) mod 4. With `lin_mode`=0 they are start XOR k.
- R7: Flow-through read: after a read edge, `rdata` shows the stored word at that edge's address, with no extra cycle. `rdata` is zero whenever `rd_drive` is low.
- R8: `rd_drive` is high only after a read edge and only while `oe_n`=0. After a write edge it stays low whatever `oe_n` is, until the next read edge.
- R9: `sleep_in` high on four consecutive edges makes the block dormant. Four consecutive low edges wake it. While dormant, `rd_drive` is low, nothing is written and the burst address does not move.
- R10: After reset, `rd_drive` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_in | input | 1 | Sleep request, high to sleep |
| cen1_n | input | 1 | Chip select, active low |
| cen2 | input | 1 | Chip select, active high |
| cen3_n | input | 1 | Chip select, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | 6 | External word address |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Read data, zero when not driven |
| rd_drive | output | 1 | High when the data bus would be driven |

## Verification
Bursts start at an address whose low bits are 01. That start gives different sequences in linear and interleaved order, so a counter that ignores the mode fails. A suspend-then-advance pattern shows whether an advance is lost or repeated. A two-of-four lane mask written over a known word, and a write with the master enable off, show whether lane mapping and gating are correct. The bench also tries writes that must not land and reads back the target to prove nothing changed: write inputs on a processor-strobe edge, writes with each chip select off, writes while dormant, and advance-writes with no burst open.

// File: rtl/sbs_pkg.sv
// Shared types for the burst memory controller.
package sbs_pkg;
    // Operation chosen for one clock edge.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_LOAD_RD,
        OP_LOAD_WR,
        OP_CONT_RD,
        OP_CONT_WR
    } sbs_op_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
// Command decoder: turns the sampled control pins into one operation per
// edge plus a lane write mask. Assumes all pins are stable around the edge.
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             cen1_n,
    input  logic             cen2,
    input  logic             cen3_n,
    input  logic             ads_proc_n,
    input  logic             ads_ctrl_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             active,
    input  logic             dormant,
    output sbs_op_e          op,
    output logic             step,
    output logic [LANES-1:0] lane_we
);
    logic [LANES-1:0] req_lanes;
    logic             sel;

    // Decode the lane request, the select state and the edge operation.
    always_comb begin
        req_lanes = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
        sel       = !cen1_n && cen2 && !cen3_n;
        op        = OP_IDLE;
        step      = 1'b0;
        if (!dormant) begin
            if (!ads_proc_n || !ads_ctrl_n) begin
                if (!sel)            op = OP_DESEL;
                else if (!ads_proc_n) op = OP_LOAD_RD;
                else                 op = (|req_lanes) ? OP_LOAD_WR : OP_LOAD_RD;
            end else if (active) begin
                op   = (|req_lanes) ? OP_CONT_WR : OP_CONT_RD;
                step = !adv_n;
            end
        end
        lane_we = (op == OP_LOAD_WR || op == OP_CONT_WR) ? req_lanes : '0;
    end
endmodule

// File: rtl/sbs_burst_addr.sv
// Burst address generator: latches a start address and steps a two-bit
// offset in linear or interleaved order. eff_addr is the address used on
// the current edge; cur_addr is the one latched by the last access.
module sbs_burst_addr #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cont,
    input  logic              step,
    input  logic              lin_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] base_q, base_sel;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt, low;

    // Pick the base and offset, then form the address for this edge.
    always_comb begin
        base_sel = load ? addr_in : base_q;
        cnt_nxt  = load ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
        low      = lin_mode ? base_sel[CNT_W-1:0] + cnt_nxt
                            : base_sel[CNT_W-1:0] ^ cnt_nxt;
        eff_addr = {base_sel[ADDR_W-1:CNT_W], low};
    end

    // Latch base, offset and access address on every load or continue edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            cur_addr <= '0;
        end else if (load || cont) begin
            base_q   <= base_sel;
            cnt_q    <= cnt_nxt;
            cur_addr <= eff_addr;
        end
    end
endmodule

// File: rtl/sbs_sleep_ctl.sv
// Sleep control: flips the dormant state after SLEEP_CYC consecutive edges
// on which sleep_in differs from it. Assumes sleep_in is already
// synchronous to clk.
module sbs_sleep_ctl #(
    parameter int SLEEP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_in,
    output logic dormant
);
    localparam int CW = $clog2(SLEEP_CYC + 1);
    logic [CW-1:0] run_q;

    // Count consecutive differing edges and toggle on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dormant <= 1'b0;
            run_q   <= '0;
        end else if (sleep_in == dormant) begin
            run_q <= '0;
        end else if (run_q == CW'(SLEEP_CYC - 1)) begin
            dormant <= ~dormant;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/sbs_lane_store.sv
// Behavioural storage: one array per byte lane, written on the edge and
// read without a clock. Contents are not reset.
module sbs_lane_store #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        // Write this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/sbs_ctrl_top.sv
// Top of the burst memory command controller. It ties together the
// decoder, burst address generator, sleep control and lane store, and
// keeps the burst-open and read-data flags behind the output drive.
module sbs_ctrl_top
    import sbs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LANE_W    = 9,
    parameter int LANES     = 4,
    parameter int SLEEP_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_in,
    input  logic                    cen1_n,
    input  logic                    cen2,
    input  logic                    cen3_n,
    input  logic                    ads_proc_n,
    input  logic                    ads_ctrl_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    lin_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_drive
);
    localparam int DATA_W = LANES * LANE_W;

    sbs_op_e           op;
    logic              step, dormant, active_q, rd_flag_q;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] eff_addr, burst_addr;
    logic [DATA_W-1:0] store_q;

    sbs_sleep_ctl #(.SLEEP_CYC(SLEEP_CYC)) i_sleep (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .dormant(dormant)
    );

    sbs_cmd_decode #(.LANES(LANES)) i_dec (
        .cen1_n(cen1_n), .cen2(cen2), .cen3_n(cen3_n),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .active(active_q), .dormant(dormant),
        .op(op), .step(step), .lane_we(lane_we)
    );

    sbs_burst_addr #(.ADDR_W(ADDR_W), .CNT_W(2)) i_addr (
        .clk(clk), .rst_n(rst_n),
        .load(op == OP_LOAD_RD || op == OP_LOAD_WR),
        .cont(op == OP_CONT_RD || op == OP_CONT_WR),
        .step(step), .lin_mode(lin_mode), .addr_in(addr),
        .eff_addr(eff_addr), .cur_addr(burst_addr)
    );

    sbs_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_store (
        .clk(clk), .lane_we(lane_we), .wr_addr(eff_addr), .wdata(wdata),
        .rd_addr(burst_addr), .rd_data(store_q)
    );

    // Track whether a burst is open and whether the last access was a read.
    always_ff @(posedge clk) begin
        if (!rst_n || dormant) begin
            active_q  <= 1'b0;
            rd_flag_q <= 1'b0;
        end else begin
            case (op)
                OP_DESEL:   begin active_q <= 1'b0; rd_flag_q <= 1'b0; end
                OP_LOAD_RD: begin active_q <= 1'b1; rd_flag_q <= 1'b1; end
                OP_LOAD_WR: begin active_q <= 1'b1; rd_flag_q <= 1'b0; end
                OP_CONT_RD: rd_flag_q <= 1'b1;
                OP_CONT_WR: rd_flag_q <= 1'b0;
                default:    ;
            endcase
        end
    end

    // Output drive follows the read flag, gated by the enable and sleep.
    always_comb begin
        rd_drive = rd_flag_q && !oe_n && !dormant;
        rdata    = rd_drive ? store_q : '0;
    end
endmodule

// File: rtl/sbs_ctrl_chk.sv
// Property checker for sbs_ctrl_top, bound to every instance of it.
module sbs_ctrl_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen1_n,
    input logic              cen2,
    input logic              cen3_n,
    input logic              ads_proc_n,
    input logic              ads_ctrl_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic              dormant,
    input logic [LANES-1:0]  lane_we,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              rd_drive
);
    // R1
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ads_proc_n || !ads_ctrl_n) && !(!cen1_n && cen2 && !cen3_n) && !dormant)
        |=> !rd_drive);
    // R1
    desel_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ads_proc_n || !ads_ctrl_n) && !(!cen1_n && cen2 && !cen3_n))
        |-> lane_we == '0);
    // R2
    proc_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_proc_n |-> lane_we == '0);
    // R3
    global_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n && |lane_we) |-> (&lane_we));
    // R8
    wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> !rd_drive);
    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> !oe_n);
    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dormant |=> $stable(burst_addr));
    // R9
    sleep_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dormant |-> lane_we == '0);
endmodule

bind sbs_ctrl_top sbs_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) i_chk (
    .clk(clk), .rst_n(rst_n), .cen1_n(cen1_n), .cen2(cen2), .cen3_n(cen3_n),
    .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .gw_n(gw_n),
    .oe_n(oe_n), .dormant(dormant), .lane_we(lane_we),
    .burst_addr(burst_addr), .rd_drive(rd_drive)
);

// File: tb/test_sbs_ctrl_top.sv
// Directed bench for sbs_ctrl_top: one task per scenario, with a
// reference array kept in the bench.
module test_sbs_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n, sleep_in, cen1_n, cen2, cen3_n;
    logic        ads_proc_n, ads_ctrl_n, adv_n, gw_n, bwe_n, oe_n, lin_mode;
    logic [3:0]  bw_n;
    logic [5:0]  addr;
    logic [35:0] wdata, rdata;
    logic        rd_drive;
    logic [35:0] ref_mem [64];
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    sbs_ctrl_top i_sbs_ctrl_top (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .cen1_n(cen1_n),
        .cen2(cen2), .cen3_n(cen3_n), .ads_proc_n(ads_proc_n),
        .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .lin_mode(lin_mode), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_drive(rd_drive)
    );

    function automatic logic [35:0] pat(int a);
        return (36'(a) * 36'd2654435761) ^ 36'hA5A5A5A5A;
    endfunction

    task automatic chk(string req, logic [35:0] got, logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        cen1_n = 0; cen2 = 1; cen3_n = 0; ads_proc_n = 1; ads_ctrl_n = 1;
        adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; wdata = '0;
    endtask

    // Controller-strobe read of one address, then checks the word (R4, R7).
    task automatic ctrl_read(int a, string req);
        idle_in(); ads_ctrl_n = 0; addr = 6'(a);
        tick();
        idle_in();
        chk(req, {35'b0, rd_drive}, 36'd1);
        chk(req, rdata, ref_mem[a]);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 64; a++) begin
            idle_in(); ads_ctrl_n = 0; gw_n = 0; addr = 6'(a); wdata = pat(a);
            ref_mem[a] = pat(a);
            tick();
        end
        idle_in();
        chk("R8 hiz after write", {35'b0, rd_drive}, 36'd0);
        ctrl_read(17, "R4 fill readback");
        ctrl_read(63, "R4 fill readback");
    endtask

    task automatic t_proc_first();
        idle_in(); ads_proc_n = 0; addr = 6'd5; gw_n = 0; wdata = 36'h0DEADBEEF;
        tick();
        idle_in();
        chk("R2 read not write", rdata, ref_mem[5]);
        chk("R7 flow-through drive", {35'b0, rd_drive}, 36'd1);
        // write requested on the following edge goes to the loaded address
        gw_n = 0; wdata = 36'h123456789;
        tick();
        ref_mem[5] = 36'h123456789;
        chk("R8 oe ignored on write", {35'b0, rd_drive}, 36'd0);
        idle_in();
        tick();
        chk("R8 suspend read after write", rdata, ref_mem[5]);
        ctrl_read(5, "R5 write to loaded addr");
    endtask

    task automatic t_burst(logic lin);
        lin_mode = lin;
        idle_in(); ads_ctrl_n = 0; addr = 6'd9;
        tick();
        for (int k = 0; k < 4; k++) begin
            int ea;
            ea = lin ? {4'd2, 2'(2'd1 + 2'(k))} : {4'd2, 2'(2'd1 ^ 2'(k))};
            idle_in();
            chk(lin ? "R6 linear order" : "R6 interleaved order", rdata, ref_mem[ea]);
            adv_n = 0;
            if (k < 3) tick();
        end
        idle_in();
        lin_mode = 1;
    endtask

    task automatic t_suspend();
        idle_in(); ads_ctrl_n = 0; addr = 6'd12;
        tick();
        idle_in(); adv_n = 0; tick();
        chk("R5 advance", rdata, ref_mem[13]);
        idle_in(); tick();
        chk("R5 suspend holds", rdata, ref_mem[13]);
        idle_in(); adv_n = 0; tick();
        chk("R5 resume", rdata, ref_mem[14]);
        // advance-write
        idle_in(); adv_n = 0; gw_n = 0; wdata = 36'hABCABCABC; tick();
        ref_mem[15] = 36'hABCABCABC;
        idle_in();
        ctrl_read(15, "R5 advance write");
    endtask

    task automatic t_bytes();
        idle_in(); ads_ctrl_n = 0; addr = 6'd20; bwe_n = 0; bw_n = 4'b1010;
        wdata = 36'hFFFFFFFFF;
        tick();
        ref_mem[20][8:0]   = 9'h1FF;
        ref_mem[20][26:18] = 9'h1FF;
        idle_in();
        ctrl_read(20, "R3 lanes 0 and 2");
        // lane enables without master enable: read, no write
        idle_in(); ads_ctrl_n = 0; addr = 6'd21; bwe_n = 1; bw_n = 4'h0;
        wdata = 36'h0;
        tick();
        idle_in();
        chk("R3 master enable off", rdata, ref_mem[21]);
        ctrl_read(21, "R3 master enable off readback");
    endtask

    task automatic t_desel();
        ctrl_read(3, "R1 pre-deselect");
        idle_in(); ads_ctrl_n = 0; cen2 = 0; addr = 6'd3; tick();
        idle_in();
        chk("R1 deselect hiz", {35'b0, rd_drive}, 36'd0);
        adv_n = 0; gw_n = 0; wdata = '0; tick();
        idle_in();
        chk("R5 no burst open", {35'b0, rd_drive}, 36'd0);
        idle_in(); ads_ctrl_n = 0; cen1_n = 1; gw_n = 0; addr = 6'd3; tick();
        idle_in(); ads_proc_n = 0; cen3_n = 1; addr = 6'd4; tick();
        idle_in();
        ctrl_read(3, "R1 deselected write dropped");
        ctrl_read(4, "R1 proc deselect");
        ctrl_read(0, "R5 stray advance-write dropped");
    endtask

    task automatic t_oe();
        ctrl_read(8, "R8 read");
        oe_n = 1; #1;
        chk("R8 oe high", {35'b0, rd_drive}, 36'd0);
        chk("R7 zero when undriven", rdata, 36'd0);
        oe_n = 0; #1;
        chk("R8 oe low again", rdata, ref_mem[8]);
    endtask

    task automatic t_reset();
        ctrl_read(30, "R10 pre-reset");
        rst_n = 0; tick(); tick();
        chk("R10 reset drive", {35'b0, rd_drive}, 36'd0);
        rst_n = 1;
        idle_in(); adv_n = 0; gw_n = 0; wdata = 36'h0; tick();
        idle_in();
        chk("R10 no burst after reset", {35'b0, rd_drive}, 36'd0);
        ctrl_read(0, "R10 nothing written");
        ctrl_read(1, "R10 nothing written");
    endtask

    task automatic t_sleep();
        idle_in(); sleep_in = 1;
        tick(); tick();
        ads_ctrl_n = 0; addr = 6'd51; tick();
        idle_in();
        chk("R9 awake on third edge", rdata, ref_mem[51]);
        tick();
        ads_ctrl_n = 0; gw_n = 0; addr = 6'd50; wdata = 36'h0; tick();
        idle_in();
        chk("R9 dormant drive", {35'b0, rd_drive}, 36'd0);
        sleep_in = 0;
        tick(); tick();
        ads_ctrl_n = 0; addr = 6'd50; tick();
        idle_in();
        chk("R9 still dormant", {35'b0, rd_drive}, 36'd0);
        tick();
        ctrl_read(50, "R9 write during sleep dropped");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_in(); rst_n = 0; sleep_in = 0; lin_mode = 1; addr = '0;
        tick(); tick();
        chk("R10 reset state", {35'b0, rd_drive}, 36'd0);
        rst_n = 1; tick();
        t_fill();
        t_proc_first();
        t_burst(1'b1);
        t_burst(1'b0);
        t_suspend();
        t_bytes();
        t_desel();
        t_oe();
        t_reset();
        t_sleep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule